// File: doc/BRIEF.md
# Control Endpoint Stage Flag Logic

This block follows a control transfer on endpoint 0 and keeps the interrupt-cause flags that firmware services. A packet engine in front of it reports three single-cycle events: a setup packet was received, an OUT data packet completed (with its byte count), and an IN packet was acknowledged by the host. From these the block keeps a setup flag, an OUT-request flag, an IN-request flag, the size of the last received packet and the current stage of the transfer. It also drives one masked interrupt line.

Firmware reaches the block through a small register port. Reads are combinational. Writing a zero to a flag bit clears that flag, and writing a one leaves it alone. The IN-request flag comes out of reset already set. Before it can arm a zero-length status response, firmware has to clear it explicitly.

The stage tracker is an enumerated state machine with four states:
- IDLE (code 0)
- SETUP (code 1)
- DATA (code 2)
- STATUS (code 3)

Its transitions are:
- *setup_seen*: any state goes to SETUP on a setup event.
- *out_data*: SETUP goes to DATA on an OUT completion.
- *status_done*: SETUP or DATA goes to STATUS on an IN acknowledge.
- *hold*: every other case keeps the state.

Top module: `ep0_stage_flags`

## Requirements
- R1: After reset the flags are as follows:
  - the setup flag is 0
  - the OUT-request flag is 0
  - the IN-request flag is 1
  - the size is 0
  - both enables are 0
  - `irq` is 0
  - the stage is IDLE (code 0)
- R2: A setup event sets both the setup flag and the OUT-request flag, and loads the size field with 8 (the setup packet length) on the next clock edge.
- R3: An OUT completion without a setup event in the same cycle sets the OUT-request flag and latches `rx_count` into the size field.
- R4: An IN acknowledge sets the IN-request flag in any stage.
- R5: Hardware never clears a flag. A write to address 0 clears each flag whose data bit is 0:
  - bit 0 is the setup flag
  - bit 1 is the OUT-request flag
  - bit 2 is the IN-request flag

  A data bit of 1 leaves that flag unchanged. Writes to addresses 2 and 3 are ignored.
- R6: When hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R7: A write to address 1 loads the OUT enable from data bit 1 and the IN enable from data bit 2. `irq` equals (OUT-request AND OUT enable) OR (IN-request AND IN enable). The setup flag has no enable.
- R8: The stage follows the transitions listed above. A setup event takes priority, then an IN acknowledge, then an OUT completion.
- R9: Reads return the following:
  - address 0: the flags in bits 2:0, the stage in bits 5:4 and the size in bits 14:8
  - address 1: the enables in bits 2:1
  - addresses 2 and 3: zero

  All unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_setup | input | 1 | Setup packet received (one-cycle pulse) |
| ev_out_done | input | 1 | OUT data packet completed (one-cycle pulse) |
| ev_in_ack | input | 1 | IN packet acknowledged by host (one-cycle pulse) |
| rx_count | input | 7 | Byte count of the completed OUT packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 3 | Write data (flag or enable bits) |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| setup_flag | output | 1 | Setup marker flag |
| out_req | output | 1 | OUT-direction request flag |
| in_req | output | 1 | IN-direction request flag |
| rx_size | output | 7 | Latched received size |
| stage | output | 2 | Current transfer stage code |
| irq | output | 1 | Masked interrupt |

## Verification
Two things can land on the same clock edge: a hardware event that sets a flag, and a firmware write that clears the same flag. The bench forces this collision in directed steps. One step is a setup event alongside a write of all zeros. Another is an IN acknowledge alongside a clear of the IN-request flag. The random phase also produces many such collisions. In every case the flag must read as set after the edge, and flags with no event that cycle must show the clear. A second collision is a setup event arriving together with an OUT completion. That step is judged on the size field, which must hold 8 and not the count, and on the stage, which must be SETUP.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    typedef enum logic [1:0] {
        STG_IDLE   = 2'd0,
        STG_SETUP  = 2'd1,
        STG_DATA   = 2'd2,
        STG_STATUS = 2'd3
    } stage_e;

    localparam int FLAG_N   = 3;
    localparam int FL_SETUP = 0;
    localparam int FL_OUT   = 1;
    localparam int FL_IN    = 2;

endpackage

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
    import ep0_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ev_setup,
    input  logic   ev_out_done,
    input  logic   ev_in_ack,
    output stage_e stage_o
);

    stage_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STG_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection: setup first, then IN acknowledge, then OUT completion.
    always_comb begin
        state_d = state_q;
        if (ev_setup) begin
            state_d = STG_SETUP;                       // setup_seen
        end else begin
            unique case (state_q)
                STG_IDLE:   state_d = STG_IDLE;        // hold
                STG_SETUP: begin
                    if (ev_in_ack)        state_d = STG_STATUS;  // status_done
                    else if (ev_out_done) state_d = STG_DATA;    // out_data
                end
                STG_DATA: begin
                    if (ev_in_ack)        state_d = STG_STATUS;  // status_done
                end
                STG_STATUS: state_d = STG_STATUS;      // hold
                default:    state_d = STG_IDLE;
            endcase
        end
    end

    // Output process.
    always_comb stage_o = state_q;

    assert_setup_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (stage_o == STG_SETUP));

    assert_status_from_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_setup && ev_in_ack && stage_o == STG_DATA) |=> (stage_o == STG_STATUS));

endmodule

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // A hardware set wins over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= RST_VAL;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    assert_no_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && q_o) |=> q_o);

endmodule

// File: rtl/ep0_regif.sv
module ep0_regif
    import ep0_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 7,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FLAG_N-1:0] wdata_i,
    input  logic [FLAG_N-1:0] flags_i,
    input  logic [CNT_W-1:0]  size_i,
    input  stage_e            stage_i,
    output logic [FLAG_N-1:0] clr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int STG_LSB  = 4;
    localparam int SIZE_LSB = 8;

    logic stat_sel, en_sel;
    logic en_out_q, en_in_q;

    assign stat_sel = (addr_i == ADDR_W'(STAT_ADDR));
    assign en_sel   = (addr_i == ADDR_W'(EN_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_out_q <= 1'b0;
            en_in_q  <= 1'b0;
        end else if (wr_i && en_sel) begin
            en_out_q <= wdata_i[FL_OUT];
            en_in_q  <= wdata_i[FL_IN];
        end
    end

    // Write-zero-to-clear on the status address.
    assign clr_o = (wr_i && stat_sel) ? ~wdata_i : '0;

    always_comb begin
        rdata_o = '0;
        if (stat_sel) begin
            rdata_o[FLAG_N-1:0]            = flags_i;
            rdata_o[STG_LSB +: 2]          = stage_i;
            rdata_o[SIZE_LSB +: CNT_W]     = size_i;
        end else if (en_sel) begin
            rdata_o[FL_OUT] = en_out_q;
            rdata_o[FL_IN]  = en_in_q;
        end
    end

    assign irq_o = (flags_i[FL_OUT] & en_out_q) | (flags_i[FL_IN] & en_in_q);

    assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && en_sel && wdata_i[FL_IN]) |=> (flags_i[FL_IN] -> irq_o));

endmodule

// File: rtl/ep0_stage_flags.sv
module ep0_stage_flags
    import ep0_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 7,
    parameter int SETUP_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_setup,
    input  logic              ev_out_done,
    input  logic              ev_in_ack,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [FLAG_N-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              setup_flag,
    output logic              out_req,
    output logic              in_req,
    output logic [CNT_W-1:0]  rx_size,
    output logic [1:0]        stage,
    output logic              irq
);

    localparam logic [FLAG_N-1:0] FLAG_RST = 3'b100;

    stage_e            stage_w;
    logic [FLAG_N-1:0] set_w, clr_w, flags_w;
    logic [CNT_W-1:0]  size_q;

    ep0_stage_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_setup    (ev_setup),
        .ev_out_done (ev_out_done),
        .ev_in_ack   (ev_in_ack),
        .stage_o     (stage_w)
    );

    assign set_w[FL_SETUP] = ev_setup;
    assign set_w[FL_OUT]   = ev_setup | ev_out_done;
    assign set_w[FL_IN]    = ev_in_ack;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        ep0_flag_bit #(.RST_VAL(FLAG_RST[g])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_w[g]),
            .clr_i (clr_w[g]),
            .q_o   (flags_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           size_q <= '0;
        else if (ev_setup)    size_q <= CNT_W'(SETUP_BYTES);
        else if (ev_out_done) size_q <= rx_count;
    end

    ep0_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .flags_i (flags_w),
        .size_i  (size_q),
        .stage_i (stage_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata),
        .irq_o   (irq)
    );

    assign setup_flag = flags_w[FL_SETUP];
    assign out_req    = flags_w[FL_OUT];
    assign in_req     = flags_w[FL_IN];
    assign rx_size    = size_q;
    assign stage      = stage_w;

    assert_setup_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (setup_flag && out_req && rx_size == CNT_W'(SETUP_BYTES)));

    assert_out_latches_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_out_done && !ev_setup) |=> (out_req && rx_size == $past(rx_count)));

    assert_in_ack_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_ack |=> in_req);

endmodule

// File: tb/ep0_stage_flags_tb.sv
`timescale 1ns/1ps
module ep0_stage_flags_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_setup = 0, ev_out_done = 0, ev_in_ack = 0;
    logic [6:0]  rx_count = '0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = '0;
    logic [2:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        setup_flag, out_req, in_req, irq;
    logic [6:0]  rx_size;
    logic [1:0]  stage;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Bench model state
    logic m_setup, m_out, m_in, m_en_out, m_en_in;
    logic [6:0] m_size;
    logic [1:0] m_stage;

    always #2.5 clk = ~clk;

    ep0_stage_flags u_dut (
        .clk(clk), .rst_n(rst_n), .ev_setup(ev_setup), .ev_out_done(ev_out_done),
        .ev_in_ack(ev_in_ack), .rx_count(rx_count), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .setup_flag(setup_flag), .out_req(out_req), .in_req(in_req),
        .rx_size(rx_size), .stage(stage), .irq(irq)
    );

    function automatic logic [1:0] next_stage(logic [1:0] s, logic su, logic od, logic ia);
        if (su) return 2'd1;
        if (ia && (s == 2'd1 || s == 2'd2)) return 2'd3;
        if (od && s == 2'd1) return 2'd2;
        return s;
    endfunction

    function automatic logic [15:0] exp_rdata(logic [1:0] a);
        logic [15:0] r = '0;
        if (a == 2'd0) begin
            r[0] = m_setup; r[1] = m_out; r[2] = m_in;
            r[5:4] = m_stage; r[14:8] = m_size;
        end else if (a == 2'd1) begin
            r[1] = m_en_out; r[2] = m_en_in;
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, "/R2"}, "setup_flag", 32'(setup_flag), 32'(m_setup));
        chk({tag, "/R3"}, "out_req", 32'(out_req), 32'(m_out));
        chk({tag, "/R4"}, "in_req", 32'(in_req), 32'(m_in));
        chk({tag, "/R3"}, "rx_size", 32'(rx_size), 32'(m_size));
        chk({tag, "/R8"}, "stage", 32'(stage), 32'(m_stage));
        chk({tag, "/R7"}, "irq", 32'(irq), 32'((m_out & m_en_out) | (m_in & m_en_in)));
        chk({tag, "/R9"}, "rdata", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
    endtask

    // Drive at negedge, model updates with the edge, compare at the next negedge.
    task automatic step(string tag, logic su, logic od, logic ia, logic [6:0] cnt,
                        logic wr, logic [1:0] a, logic [2:0] wd);
        logic [2:0] clr;
        ev_setup = su; ev_out_done = od; ev_in_ack = ia; rx_count = cnt;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        clr = (wr && a == 2'd0) ? ~wd : 3'b000;
        m_stage = next_stage(m_stage, su, od, ia);
        m_setup = su | (m_setup & ~clr[0]);
        m_out   = su | od | (m_out & ~clr[1]);
        m_in    = ia | (m_in & ~clr[2]);
        if (su) m_size = 7'd8;
        else if (od) m_size = cnt;
        if (wr && a == 2'd1) begin m_en_out = wd[1]; m_en_in = wd[2]; end
        @(negedge clk);
        ev_setup = 0; ev_out_done = 0; ev_in_ack = 0; reg_wr = 0;
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_setup = 0; m_out = 0; m_in = 1; m_en_out = 0; m_en_in = 0;
        m_size = '0; m_stage = 2'd0;
        // R1: reset state, status then enable register
        reg_addr = 2'd0; #0.1;
        chk("R1", "in_req", 32'(in_req), 32'd1);
        chk("R1", "irq", 32'(irq), 32'd0);
        check_all("R1");
        reg_addr = 2'd1; #0.1;
        check_all("R1");

        // R2 setup; R8 IDLE->SETUP
        step("R2", 1, 0, 0, 7'd0, 0, 2'd0, 3'b000);
        // R5 clear IN flag only (bit 2 = 0) to arm status
        step("R5", 0, 0, 0, 7'd0, 1, 2'd0, 3'b011);
        // R3 OUT completion size 37; R8 SETUP->DATA
        step("R3", 0, 1, 0, 7'd37, 0, 2'd0, 3'b000);
        // R7 enable both interrupts
        step("R7", 0, 0, 0, 7'd0, 1, 2'd1, 3'b110);
        // R4 IN ack; R8 DATA->STATUS
        step("R4", 0, 0, 1, 7'd0, 0, 2'd1, 3'b000);
        // R5 ignored write to address 3, read status
        step("R5", 0, 0, 0, 7'd0, 1, 2'd3, 3'b000);
        // R5 no hardware clear across idle cycles
        step("R5", 0, 0, 0, 7'd0, 0, 2'd0, 3'b000);
        // R6 setup together with clear-all
        step("R6", 1, 0, 0, 7'd0, 1, 2'd0, 3'b000);
        // R6 IN ack together with clear of IN flag
        step("R6", 0, 0, 1, 7'd0, 1, 2'd0, 3'b011);
        // R8 setup with OUT completion: size must be 8
        step("R8", 1, 1, 0, 7'd99, 0, 2'd0, 3'b000);
        // R8 IN ack beats OUT completion in SETUP
        step("R8", 0, 1, 1, 7'd5, 0, 2'd0, 3'b000);
        // R7 disable, R9 read unmapped address
        step("R7", 0, 0, 0, 7'd0, 1, 2'd1, 3'b000);
        step("R9", 0, 0, 0, 7'd0, 0, 2'd2, 3'b000);

        for (int i = 0; i < 3000; i++) begin
            step("rand",
                 ($urandom % 8) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
                 7'($urandom % 65), ($urandom % 3) == 0,
                 2'($urandom), 3'($urandom));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule